// File: doc/BRIEF.md
# Manchester Line Decoder with Edge-Interval Classification

This block turns the raw on/off-keyed output of a radio receiver back into data bytes. It assumes a Manchester line code: a rising transition in the middle of a bit period stands for 1 and a falling one for 0. It does not sample the line at mid-bit. It measures the time between successive edges in ticks of a 1 µs timebase and sorts each measurement into one of two classes. A short interval is about half a bit period and a long interval is about one full bit period. A pending-mid-bit flag then rebuilds the bit stream from the sequence of classes.

A frame starts with a preamble of alternating bits. That preamble has transitions only at bit centres, so it appears as a run of long intervals. The controller has three states: `ST_IDLE`, `ST_SYNC` and `ST_DATA`.
- `ST_IDLE` leaves for `ST_SYNC` on a rising edge.
- `ST_SYNC` counts long intervals. It moves on to `ST_DATA` once the preamble count reaches the lock length. It falls back to `ST_IDLE` on any other interval.
- `ST_DATA` decodes bits. It falls back to `ST_IDLE` on any interval that breaks the code.

A stretch with no edge long enough to wrap the interval counter counts as a timeout. A timeout is treated as an invalid interval.

Decoded bits are packed into an on-block byte store. A host reads back the number of bits received and reads any stored byte through an index port. Every new lock restarts the store from byte 0.

Top module: `manchester_rx_decoder`

## Requirements
- R1: After reset, `bits_received` is 0, every stored byte reads 0, and the controller is in `ST_IDLE`.
- R2: In `ST_IDLE`, falling edges and counter timeouts are ignored. A rising edge moves the controller to `ST_SYNC` with a preamble count of 1.
- R3: In `ST_SYNC`, an edge of either direction whose interval is LONG_MIN..LONG_MAX ticks (default 200..300) increments the preamble count. Any other interval, including a timeout, returns the controller to `ST_IDLE` and leaves the store untouched.
- R4: When the preamble count reaches PRE_LEN (default 8), the controller enters `ST_DATA`. In the same step it clears the pending flag, sets the remembered bit to 0 and resets `bits_received` to 0, so that the frame is written from byte 0.
- R5: In `ST_DATA`, SHORT_MIN..SHORT_MAX ticks (default 75..175) is short and LONG_MIN..LONG_MAX is long. The decoder responds as follows:
  - A short interval with the flag clear sets the flag.
  - A short interval with the flag set emits the remembered bit and clears the flag.
  - A long interval with the flag clear inverts the remembered bit and emits it.
- R6: In `ST_DATA`, the controller returns to `ST_IDLE` on any of these: a long interval while the flag is set, an interval in neither class, or a timeout. The bits already stored and `bits_received` are kept.
- R7: Edges are detected as follows:
  - The line passes through two flops, and an edge is any difference between them. The newer flop gives the direction.
  - The interval is the number of ticks since the previous edge, with one tick every TICK_DIV clocks.
  - Both the tick prescaler and the counter restart on every edge.
  - 2^CNT_W ticks without an edge produce a timeout and restart the counter.
- R8: Bit n of a frame is stored in byte n/8 at bit position 7-(n mod 8), so the first bit lands in the most significant bit. `bits_received` equals the number of bits stored in the current frame.
- R9: Once BUF_BYTES*8 bits are stored, further bits of that frame are dropped, and `bits_received` stays at BUF_BYTES*8.
- R10: `rd_byte` shows the stored byte selected by `rd_index` in the same cycle. Bytes beyond the current frame's count keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Receiver data line, already synchronous to `clk` |
| rd_index | input | $clog2(BUF_BYTES) | Byte index for reading the store |
| rd_byte | output | 8 | Stored byte at `rd_index` |
| bits_received | output | $clog2(BUF_BYTES*8+1) | Bits stored since the last preamble lock |

## Verification
Suppose the pending flag or the remembered bit is wrong. The next stored byte then differs from the sent byte as soon as its eighth bit is written, which is about eight bit periods after the fault. Suppose instead the controller stays in `ST_SYNC` or `ST_DATA` when it should have dropped out. This is visible only later: a lock appears where none should be, and `bits_received` drops to 0 and then climbs in the middle of what should be dead line. The bench therefore keeps watching the count and each finished byte between frames, and does not only read results at the end.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } mdec_state_e;

endpackage

// File: rtl/mdec_edge_sense.sv
module mdec_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_seen,
    output logic edge_rise
);

    logic stage_new;
    logic stage_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_new <= 1'b0;
            stage_old <= 1'b0;
        end else begin
            stage_new <= line_in;
            stage_old <= stage_new;
        end
    end

    assign edge_seen = stage_new ^ stage_old;
    assign edge_rise = stage_new;

endmodule

// File: rtl/mdec_interval_timer.sv
module mdec_interval_timer #(
    parameter int TICK_DIV = 100,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] interval,
    output logic             overflow
);

    logic tick;

    generate
        if (TICK_DIV == 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (restart || pre_q == PRE_LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + PW'(1);
                end
            end

            assign tick = (pre_q == PRE_LAST);
        end
    endgenerate

    assign overflow = !restart && tick && (interval == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval <= '0;
        end else if (restart) begin
            interval <= '0;
        end else if (tick) begin
            interval <= interval + CNT_W'(1);
        end
    end

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (interval == '0)); // R7

    AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (interval == '0)); // R7

endmodule

// File: rtl/mdec_fsm.sv
module mdec_fsm
    import mdec_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SHORT_MIN = 75,
    parameter int SHORT_MAX = 175,
    parameter int LONG_MIN  = 200,
    parameter int LONG_MAX  = 300,
    parameter int PRE_LEN   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_seen,
    input  logic             edge_rise,
    input  logic             overflow,
    input  logic [CNT_W-1:0] interval,
    output logic             bit_valid,
    output logic             bit_val,
    output logic             frame_start
);

    localparam int PRE_W = $clog2(PRE_LEN + 1);
    localparam logic [CNT_W-1:0] SH_LO = CNT_W'(SHORT_MIN);
    localparam logic [CNT_W-1:0] SH_HI = CNT_W'(SHORT_MAX);
    localparam logic [CNT_W-1:0] LG_LO = CNT_W'(LONG_MIN);
    localparam logic [CNT_W-1:0] LG_HI = CNT_W'(LONG_MAX);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_LEN - 1);

    mdec_state_e      state, state_n;
    logic [PRE_W-1:0] pre_cnt, pre_n;
    logic             pend, pend_n;
    logic             last, last_n;
    logic             emit_n, emit_val_n, start_n;

    logic in_short, in_long, ev_short, ev_long, ev_bad;

    assign in_short = (interval >= SH_LO) && (interval <= SH_HI);
    assign in_long  = (interval >= LG_LO) && (interval <= LG_HI);
    assign ev_short = edge_seen && in_short;
    assign ev_long  = edge_seen && in_long;
    assign ev_bad   = overflow || (edge_seen && !in_short && !in_long);

    always_comb begin
        state_n    = state;
        pre_n      = pre_cnt;
        pend_n     = pend;
        last_n     = last;
        emit_n     = 1'b0;
        emit_val_n = 1'b0;
        start_n    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (edge_seen && edge_rise) begin
                    state_n = ST_SYNC;
                    pre_n   = PRE_W'(1);
                end
            end
            ST_SYNC: begin
                if (ev_long) begin
                    if (pre_cnt == PRE_LAST) begin
                        state_n = ST_DATA;
                        pend_n  = 1'b0;
                        last_n  = 1'b0;
                        start_n = 1'b1;
                    end else begin
                        pre_n = pre_cnt + PRE_W'(1);
                    end
                end else if (ev_short || ev_bad) begin
                    state_n = ST_IDLE;
                end
            end
            ST_DATA: begin
                if (ev_short) begin
                    if (pend) begin
                        emit_n     = 1'b1;
                        emit_val_n = last;
                        pend_n     = 1'b0;
                    end else begin
                        pend_n = 1'b1;
                    end
                end else if (ev_long && !pend) begin
                    last_n     = ~last;
                    emit_n     = 1'b1;
                    emit_val_n = ~last;
                end else if (ev_long || ev_bad) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pre_cnt <= '0;
            pend    <= 1'b0;
            last    <= 1'b0;
        end else begin
            state   <= state_n;
            pre_cnt <= pre_n;
            pend    <= pend_n;
            last    <= last_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid   <= 1'b0;
            bit_val     <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            bit_valid   <= emit_n;
            bit_val     <= emit_val_n;
            frame_start <= start_n;
        end
    end

    AST_IDLE_FALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && edge_seen && !edge_rise) |=> (state == ST_IDLE)); // R2

    AST_IDLE_RISE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && edge_seen && edge_rise) |=> (state == ST_SYNC)); // R2

    AST_SYNC_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && overflow) |=> (state == ST_IDLE)); // R3

    AST_LONG_PEND_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && pend && edge_seen && interval >= LG_LO && interval <= LG_HI)
        |=> (state == ST_IDLE)); // R6

    AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (state == ST_DATA && !pend && !last)); // R4

    AST_EMIT_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> ($past(state) == ST_DATA)); // R5

endmodule

// File: rtl/mdec_rx_buffer.sv
module mdec_rx_buffer #(
    parameter int BUF_BYTES = 128
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               frame_start,
    input  logic                               bit_valid,
    input  logic                               bit_val,
    input  logic [$clog2(BUF_BYTES)-1:0]       rd_index,
    output logic [7:0]                         rd_byte,
    output logic [$clog2(BUF_BYTES*8+1)-1:0]   bits_stored
);

    localparam int IDX_W  = $clog2(BUF_BYTES);
    localparam int BITS_W = $clog2(BUF_BYTES * 8 + 1);
    localparam logic [BITS_W-1:0] CAP = BITS_W'(BUF_BYTES * 8);

    logic [7:0]       mem [BUF_BYTES];
    logic [IDX_W-1:0] wr_idx;
    logic [2:0]       wr_pos;

    assign wr_idx = bits_stored[IDX_W+2:3];
    assign wr_pos = 3'd7 - bits_stored[2:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_stored <= '0;
            for (int i = 0; i < BUF_BYTES; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (frame_start) begin
            bits_stored <= '0;
        end else if (bit_valid && bits_stored != CAP) begin
            mem[wr_idx][wr_pos] <= bit_val;
            bits_stored         <= bits_stored + BITS_W'(1);
        end
    end

    assign rd_byte = mem[rd_index];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bits_stored <= CAP); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bits_stored) |-> (bits_stored == '0 ||
                                   bits_stored == $past(bits_stored) + BITS_W'(1))); // R8

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_stored == CAP && !frame_start) |=> (bits_stored == CAP)); // R9

endmodule

// File: rtl/manchester_rx_decoder.sv
module manchester_rx_decoder #(
    parameter int TICK_DIV  = 100,
    parameter int CNT_W     = 16,
    parameter int SHORT_MIN = 75,
    parameter int SHORT_MAX = 175,
    parameter int LONG_MIN  = 200,
    parameter int LONG_MAX  = 300,
    parameter int PRE_LEN   = 8,
    parameter int BUF_BYTES = 128
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rx_line,
    input  logic [$clog2(BUF_BYTES)-1:0]     rd_index,
    output logic [7:0]                       rd_byte,
    output logic [$clog2(BUF_BYTES*8+1)-1:0] bits_received
);

    logic             edge_seen;
    logic             edge_rise;
    logic             overflow;
    logic [CNT_W-1:0] interval;
    logic             bit_valid;
    logic             bit_val;
    logic             frame_start;

    mdec_edge_sense u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (rx_line),
        .edge_seen (edge_seen),
        .edge_rise (edge_rise)
    );

    mdec_interval_timer #(
        .TICK_DIV (TICK_DIV),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (edge_seen),
        .interval (interval),
        .overflow (overflow)
    );

    mdec_fsm #(
        .CNT_W     (CNT_W),
        .SHORT_MIN (SHORT_MIN),
        .SHORT_MAX (SHORT_MAX),
        .LONG_MIN  (LONG_MIN),
        .LONG_MAX  (LONG_MAX),
        .PRE_LEN   (PRE_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_seen   (edge_seen),
        .edge_rise   (edge_rise),
        .overflow    (overflow),
        .interval    (interval),
        .bit_valid   (bit_valid),
        .bit_val     (bit_val),
        .frame_start (frame_start)
    );

    mdec_rx_buffer #(
        .BUF_BYTES (BUF_BYTES)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .bit_valid   (bit_valid),
        .bit_val     (bit_val),
        .rd_index    (rd_index),
        .rd_byte     (rd_byte),
        .bits_stored (bits_received)
    );

endmodule

// File: tb/test_manchester_rx_decoder.sv
`timescale 1ns/1ps
module test_manchester_rx_decoder;

    localparam int D  = 2;
    localparam int CW = 10;
    localparam int NB = 4;
    localparam int IW = $clog2(NB);
    localparam int BW = $clog2(NB * 8 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_line = 1'b0;
    logic [IW-1:0] rd_index = '0;
    logic [7:0]    rd_byte;
    logic [BW-1:0] bits_received;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q [$];
    int prev_bits = 0;

    always #2.5 clk = ~clk;

    manchester_rx_decoder #(
        .TICK_DIV  (D),
        .CNT_W     (CW),
        .BUF_BYTES (NB)
    ) i_manchester_rx_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_line       (rx_line),
        .rd_index      (rd_index),
        .rd_byte       (rd_byte),
        .bits_received (bits_received)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int us);
        rx_line = lvl;
        repeat (us * D) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        if (b) begin
            drive(1'b0, 125);
            drive(1'b1, 125);
        end else begin
            drive(1'b1, 125);
            drive(1'b0, 125);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input bit expect_it);
        if (expect_it) exp_q.push_back(v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_preamble();
        send_byte(8'hAA, 1'b0);
    endtask

    task automatic quiet();
        drive(rx_line, 1300);
    endtask

    task automatic check_drained(input string tag);
        check(tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Scoreboard monitor: compares each byte as its last bit is stored (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(bits_received) != prev_bits) begin
                prev_bits = int'(bits_received);
                if (prev_bits != 0 && prev_bits % 8 == 0) begin
                    rd_index = IW'(prev_bits / 8 - 1);
                    #1;
                    if (exp_q.size() == 0) begin
                        n_checks++;
                        n_fail++;
                        $display("FAIL R8: unexpected byte 0x%0h at index %0d, expected none",
                                 rd_byte, prev_bits / 8 - 1);
                    end else begin
                        check("R8 byte packing", int'(rd_byte), int'(exp_q.pop_front()));
                    end
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset count", int'(bits_received), 0);
        check("R1 reset byte", int'(rd_byte), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R5 mixed bits; frame ends low
        send_preamble();
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b1);
        quiet();
        check("R5 frame count", int'(bits_received), 16);
        check_drained("R5 bytes seen");

        // R5 runs of equal bits (short pairs); ends high; R4 restart at 0
        send_preamble();
        send_byte(8'h00, 1'b1);
        send_byte(8'hFF, 1'b1);
        quiet();
        check("R4 relock count", int'(bits_received), 16);
        check_drained("R5 equal bits");

        // R2 frame begins with a falling edge while idle
        send_preamble();
        send_byte(8'h69, 1'b1);
        quiet();
        check("R2 falling ignored", int'(bits_received), 8);
        check_drained("R2 bytes seen");

        // R3 a 150 us interval breaks the preamble
        drive(1'b0, 125);
        drive(1'b1, 250);
        drive(1'b0, 250);
        drive(1'b1, 150);
        drive(1'b0, 250);
        drive(1'b1, 250);
        drive(1'b0, 250);
        drive(1'b1, 250);
        drive(1'b0, 250);
        quiet();
        check("R3 bad preamble interval", int'(bits_received), 8);

        // R3 R7 timeout during preamble
        drive(1'b0, 125);
        drive(1'b1, 250);
        drive(1'b0, 250);
        drive(1'b1, 250);
        drive(1'b0, 1300);
        drive(1'b1, 250);
        drive(1'b0, 250);
        drive(1'b1, 250);
        drive(1'b0, 250);
        send_byte(8'h00, 1'b0);
        quiet();
        check("R7 timeout in sync", int'(bits_received), 8);
        check_drained("R3 no lock");

        // R6 out-of-class gap during data
        send_preamble();
        send_byte(8'h5A, 1'b1);
        drive(1'b0, 400);
        send_byte(8'h81, 1'b0);
        quiet();
        check("R6 gap abort", int'(bits_received), 8);
        check_drained("R6 gap bytes");

        // R6 long interval with pending flag set
        send_preamble();
        send_byte(8'h5A, 1'b1);
        drive(1'b1, 250);
        send_byte(8'hC3, 1'b0);
        quiet();
        check("R6 pending long abort", int'(bits_received), 8);
        check_drained("R6 pending bytes");

        // R9 overrun: fifth byte dropped
        send_preamble();
        send_byte(8'h11, 1'b1);
        send_byte(8'h22, 1'b1);
        send_byte(8'h44, 1'b1);
        send_byte(8'h88, 1'b1);
        send_byte(8'hF0, 1'b0);
        quiet();
        check("R9 full count", int'(bits_received), 32);
        check_drained("R9 bytes seen");

        // R10 new frame overwrites from index 0, older bytes remain
        send_preamble();
        send_byte(8'h96, 1'b1);
        quiet();
        check("R10 count", int'(bits_received), 8);
        check_drained("R10 byte seen");
        rd_index = IW'(0);
        #1;
        check("R10 read index 0", int'(rd_byte), 8'h96);
        rd_index = IW'(1);
        #1;
        check("R10 read index 1", int'(rd_byte), 8'h22);
        rd_index = IW'(3);
        #1;
        check("R10 read index 3", int'(rd_byte), 8'h88);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule